// File: doc/BRIEF.md
# Binary/Decimal Add-Subtract Unit

This unit performs the 8-bit add-with-carry and subtract-with-borrow of an 8-bit processor datapath. A mode input chooses between plain binary arithmetic and packed-BCD arithmetic. In packed BCD each nibble holds one decimal digit. The unit returns an 8-bit result and four flags: negative (N), overflow (V), zero (Z) and carry (C). In decimal mode, every one of the 256×256×2 operand and carry combinations gives a fixed, defined answer. This holds for operands that are not valid BCD as well. The answers reproduce the digit-adjust arithmetic and flag quirks of three processor variants: an older variant, a later variant and a wide-register variant.

The variant is fixed by a parameter. A one-cycle `start` pulse presents the operands. Results and flags are registered and appear with a one-cycle `done` pulse. The later variant needs one extra clock to finish a decimal operation, and `ready` is low during that clock. Instruction decode and register storage belong to the surrounding processor.

Top module: `dm_alu`

## Requirements
- R1: Binary add (dec_mode=0, sub_op=0).
  - result = (A+B+Cin) mod 256.
  - C = 1 when A+B+Cin > 255.
  - V = two's-complement overflow of the signed sum.
  - N = result bit 7; Z = (result == 0).
  - These rules hold for all variants.
- R2: Binary subtract (dec_mode=0, sub_op=1).
  - result = (A−B−1+Cin) mod 256.
  - C = 1 when A−B−1+Cin ≥ 0, meaning no borrow.
  - V = signed overflow of the difference.
  - N = result bit 7; Z = (result == 0).
- R3: Decimal add, result and carry, all variants.
  - Low sum L = A[3:0]+B[3:0]+Cin. If L ≥ 0x0A, L becomes ((L+6)&0x0F)+0x10.
  - Full sum F = (A&0xF0)+(B&0xF0)+L. If F ≥ 0xA0, 0x60 is added to F.
  - result = F[7:0]; C = 1 when F ≥ 0x100.
- R4: Decimal add, V and the older variant's N and Z.
  - V = 1 when the pre-correction full sum, taken with A&0xF0 and B&0xF0 as signed bytes, lies outside −128..127.
  - On the older variant, N = bit 7 of that pre-correction sum.
  - On the older variant, Z = 1 when the binary sum (A+B+Cin) mod 256 is 0.
- R5: On the later and wide variants, decimal add and decimal subtract take N = result bit 7 and Z = (result == 0).
- R6: Decimal subtract result on the older and wide variants.
  - Low difference L = A[3:0]−B[3:0]+Cin−1. If L < 0, L becomes ((L−6)&0x0F)−0x10.
  - Full value F = (A&0xF0)−(B&0xF0)+L. If F < 0, 0x60 is subtracted from F.
  - result = F mod 256.
- R7: Decimal subtract result on the later variant.
  - Full value F = A−B+Cin−1. If F < 0, 0x60 is subtracted from F.
  - If A[3:0]−B[3:0]+Cin−1 < 0, a further 6 is subtracted.
  - result = F mod 256.
- R8: Decimal subtract flags.
  - On every variant, C and V equal the binary subtract flags of the same inputs.
  - On the older variant, N and Z also equal the binary subtract flags.
- R9: Latency.
  - `done` is high in the cycle after an accepted `start`.
  - On the later variant in decimal mode, `done` comes one cycle later instead.
- R10: The later variant's extra decimal cycle.
  - During that cycle `ready` is 0 and `result` holds its value.
  - A `start` in that cycle is ignored: no extra `done` appears, and the pending result is unchanged.
- R11: After reset, `done`=0, `ready`=1, and `result` and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle request; operands are sampled with it |
| dec_mode | input | 1 | 1 = packed-BCD arithmetic, 0 = binary |
| sub_op | input | 1 | 1 = subtract with borrow, 0 = add with carry |
| a_in | input | 8 | Accumulator operand |
| b_in | input | 8 | Second operand |
| c_in | input | 1 | Incoming carry (for a subtract, 1 = no borrow) |
| ready | output | 1 | Unit can accept a start this cycle |
| done | output | 1 | One-cycle pulse: result and flags are valid |
| result | output | 8 | Registered result |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Overflow flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |

## Verification
Two functions can fall in the same cycle: the `done` pulse that hands back one result, and the acceptance of the next `start`. The driver provokes this by issuing a new operation at the first edge where `ready` is high, so operations run back to back on every variant. The scoreboard checks each popped result against the model for the operation that produced it, and checks that `done` arrives in exactly the expected cycle. A second collision is forced on the later variant: a `start` lands in its busy decimal cycle. The check there is that no extra result is produced and that the pending result survives unchanged.

// File: rtl/dm_alu_pkg.sv
// Shared types for the binary/decimal add-subtract unit.
// Assumes an 8-bit datapath; digit-adjust constants are tied to 4-bit nibbles.
package dm_alu_pkg;
    localparam int DATA_W = 8;
    localparam int NIB_W  = DATA_W / 2;

    // Variant selects the decimal-mode arithmetic and flag rules
    typedef enum logic [1:0] {
        VAR_NMOS = 2'd0,
        VAR_CMOS = 2'd1,
        VAR_WIDE = 2'd2
    } variant_e;

    // Result bundle produced by each arithmetic core
    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              n;
        logic              v;
        logic              z;
        logic              c;
    } alu_out_t;
endpackage

// File: rtl/dm_add_unit.sv
// Combinational add-with-carry core, binary or packed-BCD.
// Assumes: operands are arbitrary bytes; decimal rules follow the selected variant.
module dm_add_unit
    import dm_alu_pkg::*;
#(
    parameter variant_e VARIANT = VAR_CMOS
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    input  logic              dec,
    output alu_out_t          o
);
    localparam int SW = DATA_W + 3;

    logic [DATA_W:0]        bin_sum;
    logic [NIB_W:0]         lo_raw;
    logic [DATA_W:0]        lo_adj;
    logic [DATA_W:0]        full;
    logic [DATA_W+1:0]      full_c;
    logic signed [SW-1:0]   sgn;
    logic                   dec_v;

    // Binary sum and the digit-adjusted intermediates
    always_comb begin
        bin_sum = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};
        lo_raw  = {1'b0, a[NIB_W-1:0]} + {1'b0, b[NIB_W-1:0]} + {{NIB_W{1'b0}}, cin};
        if (lo_raw >= 5'd10)
            lo_adj = {5'b0, 4'(lo_raw + 5'd6)} + 9'h010;
        else
            lo_adj = {4'b0, lo_raw};
        full   = {1'b0, a[7:4], 4'b0} + {1'b0, b[7:4], 4'b0} + lo_adj;
        sgn    = $signed({{3{a[7]}}, a[7:4], 4'b0}) + $signed({{3{b[7]}}, b[7:4], 4'b0})
               + $signed({2'b0, lo_adj});
        dec_v  = (sgn < -11'sd128) || (sgn > 11'sd127);
        full_c = {1'b0, full} + ((full >= 9'h0A0) ? 10'h060 : 10'h000);
    end

    // Select outputs by mode and variant flag rules
    always_comb begin
        if (!dec) begin
            o.res = bin_sum[7:0];
            o.c   = bin_sum[8];
            o.v   = (a[7] == b[7]) && (bin_sum[7] != a[7]);
            o.n   = bin_sum[7];
            o.z   = (bin_sum[7:0] == 8'h00);
        end else begin
            o.res = full_c[7:0];
            o.c   = (full_c >= 10'h100);
            o.v   = dec_v;
            if (VARIANT == VAR_NMOS) begin
                o.n = full[7];
                o.z = (bin_sum[7:0] == 8'h00);
            end else begin
                o.n = full_c[7];
                o.z = (full_c[7:0] == 8'h00);
            end
        end
    end
endmodule

// File: rtl/dm_sub_unit.sv
// Combinational subtract-with-borrow core, binary or packed-BCD.
// Assumes: cin = 1 means no borrow; the variant picks the decimal adjust order.
module dm_sub_unit
    import dm_alu_pkg::*;
#(
    parameter variant_e VARIANT = VAR_CMOS
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    input  logic              dec,
    output alu_out_t          o
);
    localparam int SW = DATA_W + 3;

    logic [DATA_W:0]      bin_d;
    logic                 bin_v;
    logic signed [SW-1:0] lo;
    logic signed [SW-1:0] dfull;
    logic [DATA_W-1:0]    dres;

    // Binary difference and the low-digit difference shared by all variants
    always_comb begin
        bin_d = {1'b0, a} + {1'b0, ~b} + {{DATA_W{1'b0}}, cin};
        bin_v = (a[7] != b[7]) && (bin_d[7] != a[7]);
        lo    = $signed({7'b0, a[3:0]}) - $signed({7'b0, b[3:0]})
              + $signed({10'b0, cin}) - 11'sd1;
    end

    // Decimal result: adjust order depends on the variant
    generate
        if (VARIANT == VAR_CMOS) begin : g_whole_first
            // Whole-byte adjust first, then the low-digit adjust
            always_comb begin
                dfull = $signed({3'b0, a}) - $signed({3'b0, b}) + $signed({10'b0, cin}) - 11'sd1;
                if (dfull < 0)
                    dfull = dfull - 11'sd96;
                if (lo < 0)
                    dfull = dfull - 11'sd6;
                dres = dfull[7:0];
            end
        end else begin : g_digit_first
            // Low digit adjusted before the high digits are combined
            logic signed [SW-1:0] lo_adj;
            always_comb begin
                lo_adj = (lo < 0) ? (((lo - 11'sd6) & 11'sd15) - 11'sd16) : lo;
                dfull  = $signed({3'b0, a[7:4], 4'b0}) - $signed({3'b0, b[7:4], 4'b0}) + lo_adj;
                if (dfull < 0)
                    dfull = dfull - 11'sd96;
                dres = dfull[7:0];
            end
        end
    endgenerate

    // Pick result and flags for the mode and variant
    always_comb begin
        o.c = bin_d[8];
        o.v = bin_v;
        if (!dec || VARIANT == VAR_NMOS) begin
            o.n = bin_d[7];
            o.z = (bin_d[7:0] == 8'h00);
        end else begin
            o.n = dres[7];
            o.z = (dres == 8'h00);
        end
        o.res = dec ? dres : bin_d[7:0];
    end
endmodule

// File: rtl/dm_alu.sv
// Top of the binary/decimal add-subtract unit with a start/done handshake.
// Assumes: start is a single-cycle pulse honoured only while ready is high;
// the later variant spends one extra cycle on decimal operations.
module dm_alu
    import dm_alu_pkg::*;
#(
    parameter variant_e VARIANT = VAR_CMOS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              dec_mode,
    input  logic              sub_op,
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    input  logic              c_in,
    output logic              ready,
    output logic              done,
    output logic [DATA_W-1:0] result,
    output logic              flag_n,
    output logic              flag_v,
    output logic              flag_z,
    output logic              flag_c
);
    localparam logic SLOW_DEC = (VARIANT == VAR_CMOS);

    alu_out_t add_o, sub_o, nxt, out_q;
    logic     busy_q, done_q, take;

    dm_add_unit #(.VARIANT(VARIANT)) u_add (
        .a(a_in), .b(b_in), .cin(c_in), .dec(dec_mode), .o(add_o)
    );

    dm_sub_unit #(.VARIANT(VARIANT)) u_sub (
        .a(a_in), .b(b_in), .cin(c_in), .dec(dec_mode), .o(sub_o)
    );

    // Operation select and acceptance qualifier
    always_comb begin
        nxt  = sub_op ? sub_o : add_o;
        take = start && !busy_q;
    end

    // Handshake state and output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (busy_q) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
            end else if (take) begin
                out_q <= nxt;
                if (SLOW_DEC && dec_mode)
                    busy_q <= 1'b1;
                else
                    done_q <= 1'b1;
            end
        end
    end

    // Drive ports from registered state
    always_comb begin
        ready  = !busy_q;
        done   = done_q;
        result = out_q.res;
        flag_n = out_q.n;
        flag_v = out_q.v;
        flag_z = out_q.z;
        flag_c = out_q.c;
    end
endmodule

// File: rtl/dm_alu_chk.sv
// Assertion checker for dm_alu, attached by bind.
// Assumes it sees only the top-level ports; it keeps its own copy of the last accepted op.
module dm_alu_chk
    import dm_alu_pkg::*;
#(
    parameter variant_e VARIANT = VAR_CMOS
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       dec_mode,
    input logic       sub_op,
    input logic [7:0] a_in,
    input logic [7:0] b_in,
    input logic       c_in,
    input logic       ready,
    input logic       done,
    input logic [7:0] result,
    input logic       flag_n,
    input logic       flag_z,
    input logic       flag_c
);
    localparam logic SLOW = (VARIANT == VAR_CMOS);

    logic       l_dec, l_sub, l_c;
    logic [7:0] l_a, l_b;

    // Capture the last accepted operation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            l_dec <= 1'b0; l_sub <= 1'b0; l_c <= 1'b0; l_a <= '0; l_b <= '0;
        end else if (start && ready) begin
            l_dec <= dec_mode; l_sub <= sub_op; l_c <= c_in; l_a <= a_in; l_b <= b_in;
        end
    end

    assert_fast_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && ready && !(SLOW && dec_mode)) |=> done);

    assert_slow_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && ready && SLOW && dec_mode) |=> (!done && !ready) ##1 done);

    assert_busy_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> (ready && done && $stable(result)));

    assert_bin_nz_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !l_dec) |-> (flag_n == result[7] && flag_z == (result == 8'h00)));

    assert_dec_nz_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && l_dec && VARIANT != VAR_NMOS) |-> (flag_n == result[7] && flag_z == (result == 8'h00)));

    assert_dec_sub_c_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && l_dec && l_sub) |-> (flag_c == ({1'b0, l_a} >= ({1'b0, l_b} + {8'b0, !l_c}))));
endmodule

bind dm_alu dm_alu_chk #(.VARIANT(VARIANT)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .dec_mode(dec_mode), .sub_op(sub_op),
    .a_in(a_in), .b_in(b_in), .c_in(c_in), .ready(ready), .done(done),
    .result(result), .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c)
);

// File: tb/tb_dm_alu.sv
// Scoreboard bench: three variants share stimulus; a driver queues expectations,
// per-variant monitors pop and compare them when done pulses.
module tb_dm_alu;
    import dm_alu_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 3;  // 0 older, 1 later, 2 wide

    typedef struct { logic [11:0] exp; int due; int kind; } item_t;

    logic clk = 0, rst_n = 0;
    logic st[NV];
    logic dec_mode = 0, sub_op = 0, c_in = 0;
    logic [7:0] a_in = 0, b_in = 0;
    logic rdy[NV], dn[NV], fn[NV], fv[NV], fz[NV], fc[NV];
    logic [7:0] res[NV];
    item_t q[NV][$];
    int cyc = 0, total = 0, bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dm_alu #(.VARIANT(VAR_NMOS)) dut_nmos (.clk(clk), .rst_n(rst_n), .start(st[0]),
        .dec_mode(dec_mode), .sub_op(sub_op), .a_in(a_in), .b_in(b_in), .c_in(c_in),
        .ready(rdy[0]), .done(dn[0]), .result(res[0]), .flag_n(fn[0]), .flag_v(fv[0]),
        .flag_z(fz[0]), .flag_c(fc[0]));
    dm_alu #(.VARIANT(VAR_CMOS)) dut (.clk(clk), .rst_n(rst_n), .start(st[1]),
        .dec_mode(dec_mode), .sub_op(sub_op), .a_in(a_in), .b_in(b_in), .c_in(c_in),
        .ready(rdy[1]), .done(dn[1]), .result(res[1]), .flag_n(fn[1]), .flag_v(fv[1]),
        .flag_z(fz[1]), .flag_c(fc[1]));
    dm_alu #(.VARIANT(VAR_WIDE)) dut_wide (.clk(clk), .rst_n(rst_n), .start(st[2]),
        .dec_mode(dec_mode), .sub_op(sub_op), .a_in(a_in), .b_in(b_in), .c_in(c_in),
        .ready(rdy[2]), .done(dn[2]), .result(res[2]), .flag_n(fn[2]), .flag_v(fv[2]),
        .flag_z(fz[2]), .flag_c(fc[2]));

    function automatic int sx(int x);
        return (x > 127) ? x - 256 : x;
    endfunction

    function automatic string tag(int kind);
        case (kind)
            0: return "R1";
            1: return "R2";
            2: return "R3/R4/R5";
            default: return "R5/R6/R7/R8";
        endcase
    endfunction

    // Reference model from the requirements: returns {res, n, v, z, c}
    function automatic logic [11:0] model(int vr, bit sb, bit dc, int a, int b, int c);
        int s, ss, al, f, sf, r, n, v, z, cf;
        if (!sb) begin
            s = a + b + c; ss = sx(a) + sx(b) + c;
            r = s & 255; cf = (s > 255); v = (ss < -128 || ss > 127);
            n = (r >> 7) & 1; z = (r == 0);
            if (dc) begin // R3 result and carry, R4 V and older N/Z, R5
                al = (a & 15) + (b & 15) + c;
                if (al >= 10) al = ((al + 6) & 15) + 16;
                f  = (a & 240) + (b & 240) + al;
                sf = sx(a & 240) + sx(b & 240) + al;
                v  = (sf < -128 || sf > 127);
                n  = (f >> 7) & 1;
                if (f >= 160) f = f + 96;
                r = f & 255; cf = (f >= 256);
                if (vr == 0) z = (((a + b + c) & 255) == 0);
                else begin n = (r >> 7) & 1; z = (r == 0); end
            end
        end else begin
            s = a - b + c - 1; ss = sx(a) - sx(b) + c - 1;
            r = s & 255; cf = (s >= 0); v = (ss < -128 || ss > 127);
            n = (r >> 7) & 1; z = (r == 0);
            if (dc) begin // R6/R7 result, R8 flags
                al = (a & 15) - (b & 15) + c - 1;
                if (vr == 1) begin
                    f = a - b + c - 1;
                    if (f < 0) f = f - 96;
                    if (al < 0) f = f - 6;
                end else begin
                    if (al < 0) al = ((al - 6) & 15) - 16;
                    f = (a & 240) - (b & 240) + al;
                    if (f < 0) f = f - 96;
                end
                r = f & 255;
                if (vr != 0) begin n = (r >> 7) & 1; z = (r == 0); end
            end
        end
        return {r[7:0], n[0], v[0], z[0], cf[0]};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    // Driver: wait for all units idle, present op, push expectations
    task automatic do_op(bit sb, bit dc, int a, int b, int c);
        while (!(rdy[0] && rdy[1] && rdy[2])) @(negedge clk);
        sub_op = sb; dec_mode = dc; a_in = 8'(a); b_in = 8'(b); c_in = c[0];
        for (int i = 0; i < NV; i++) begin
            item_t it;
            it.exp  = model(i, sb, dc, a, b, c);
            it.due  = cyc + 1 + ((i == 1 && dc) ? 1 : 0);
            it.kind = sb * 2 + (dc ? 1 : 0);
            it.kind = (it.kind == 0) ? 0 : (it.kind == 2) ? 1 : (it.kind == 1) ? 2 : 3;
            q[i].push_back(it);
            st[i] = 1'b1;
        end
        @(negedge clk);
        for (int i = 0; i < NV; i++) st[i] = 1'b0;
    endtask

    // Monitors: one per variant
    task automatic mon(int i);
        item_t it;
        if (q[i].size() == 0) begin
            check("R10 spurious done", 32'd1, 32'd0);
        end else begin
            it = q[i].pop_front();
            check({tag(it.kind), " result/flags"},
                  {20'd0, res[i], fn[i], fv[i], fz[i], fc[i]}, {20'd0, it.exp});
            check("R9 latency", 32'(cyc), 32'(it.due));
        end
    endtask

    always @(negedge clk) if (rst_n && !finished) begin
        for (int i = 0; i < NV; i++) if (dn[i]) mon(i);
    end

    // Watchdog
    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            finished = 1;
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NV; i++) st[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11 reset state on each variant
        for (int i = 0; i < NV; i++) begin
            check("R11 done", 32'(dn[i]), 32'd0);
            check("R11 ready", 32'(rdy[i]), 32'd1);
            check("R11 outputs", {20'd0, res[i], fn[i], fv[i], fz[i], fc[i]}, 32'd0);
        end

        // Directed corner cases
        do_op(0, 1, 8'h99, 8'h01, 0); // R3 wrap to 0x00 C=1; R4 older Z=0; R5 later Z=1
        do_op(0, 1, 8'h58, 8'h46, 1); // R3 0x05 C=1
        do_op(1, 1, 8'h12, 8'h21, 1); // R6/R7 0x91 C=0
        do_op(1, 1, 8'h90, 8'h0F, 1); // R6 0x8B, R7 0x7B (invalid BCD)
        do_op(0, 1, 8'h90, 8'h90, 0); // R4 V set on every variant
        do_op(0, 0, 8'h58, 8'h46, 1); // R1 0x9F with V
        do_op(1, 0, 8'h00, 8'h01, 1); // R2 wrap 0xFF C=0
        do_op(1, 1, 8'h00, 8'h01, 1); // R8 decimal 0x99 borrow
        do_op(1, 1, 8'h01, 8'h01, 1); // R5 zero result, R8 older Z

        // R10: start while the later variant is busy is ignored
        do_op(0, 1, 8'h27, 8'h35, 0);
        check("R10 ready low in extra cycle", 32'(rdy[1]), 32'd0);
        a_in = 8'h11; b_in = 8'h22; st[1] = 1'b1;
        @(negedge clk);
        st[1] = 1'b0;
        repeat (2) @(negedge clk);
        check("R10 no pending item", 32'(q[1].size()), 32'd0);
        check("R10 result kept", 32'(res[1]), 32'h62);

        // Sweep across valid and invalid codes, back to back
        for (int a = 0; a < 256; a += 17)
            for (int b = 3; b < 256; b += 23)
                for (int m = 0; m < 8; m++)
                    do_op(m[0], m[1], a, b, m[2]);

        repeat (4) @(negedge clk);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule